// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block steers a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). The instruction set is small: ADD, SUB, LOAD and STORE, with a NOP encoded as ADD of register 0 into register 0. The datapath feeds the block with the register indices, opcodes and immediate flags of the instructions in decode, execute, memory and writeback. It also supplies a memory-wait indication and a taken-branch indication with its target address.

Every cycle the block returns the following controls:
- the bypass multiplexer selects for both execute operands;
- the load-use stall indication;
- a hold bit for each stage;
- a bubble-insert control for execute;
- a flush bit for each stage;
- the program-counter source.

The block also keeps the program counter register. Three events are resolved in a fixed order: a memory wait freezes the whole pipe, a taken branch comes next, and a load-use stall comes last. The register file, ALU and memories sit outside the block.

Stage bits are numbered by stage position: bit 0 is fetch, bit 1 decode, bit 2 execute, bit 3 memory and bit 4 writeback. Opcodes are 2'b00 ADD, 2'b01 SUB, 2'b10 LOAD and 2'b11 STORE. The bypass select encodings are 2'b00 register file, 2'b01 memory-stage result and 2'b10 writeback-stage result. The PC source encodings are 2'b00 step, 2'b01 hold and 2'b10 branch target.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `pc_q` is 0.
- R2: With no memory wait, no taken branch and no load-use hazard, `pc_sel` is 2'b00, `stage_hold`, `stage_flush` and `ex_bubble` are all zero, and `pc_q` grows by PC_STEP (modulo 2^PC_W) at the next clock edge.
- R3: A load-use hazard exists when `ex_op` is 2'b10 (LOAD) and `ex_dst` equals `id_src1`, or equals `id_src2`. The comparison includes register 0. With no memory wait and no taken branch, a hazard drives `load_use_stall` high.
- R4: When `id_src2_imm` is 1, `id_src2` is ignored in the hazard comparison.
- R5: During a load-use stall, `stage_hold` is 5'b00011 (fetch and decode held), `ex_bubble` is 1, `stage_flush` is zero, `pc_sel` is 2'b01, and `pc_q` keeps its value across the edge.
- R6: For each execute operand, the select is 2'b01 when the memory stage holds an ADD or SUB whose destination matches the operand. Otherwise it is 2'b10 when the writeback stage holds an ADD, SUB or LOAD whose destination matches. Otherwise it is 2'b00. A LOAD in the memory stage is never a bypass source.
- R7: A source index of 0 always selects 2'b00. Operand B selects 2'b00 whenever `ex_src2_imm` is 1.
- R8: While `mem_wait` is 1, the following hold: `stage_hold` is 5'b11111, `stage_flush` is zero, `ex_bubble` is 0, `load_use_stall` is 0, `pc_sel` is 2'b01, and `pc_q` keeps its value. This applies even when a branch or a hazard is present.
- R9: When `br_taken` is 1 and `mem_wait` is 0, the following hold: `stage_flush` is 5'b00111, `stage_hold` is zero, `load_use_stall` and `ex_bubble` are 0, `pc_sel` is 2'b10, and `pc_q` takes `br_target` at the next edge.
- R10: With parameter FWD_ENABLE set to 0, both bypass selects are always 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_src1 | input | REG_ADDR_W | Decode-stage first source index |
| id_src2 | input | REG_ADDR_W | Decode-stage second source index |
| id_src2_imm | input | 1 | Decode-stage second operand is an immediate |
| ex_op | input | 2 | Execute-stage opcode |
| ex_dst | input | REG_ADDR_W | Execute-stage destination index |
| ex_src1 | input | REG_ADDR_W | Execute-stage first source index |
| ex_src2 | input | REG_ADDR_W | Execute-stage second source index |
| ex_src2_imm | input | 1 | Execute-stage second operand is an immediate |
| mem_op | input | 2 | Memory-stage opcode |
| mem_dst | input | REG_ADDR_W | Memory-stage destination index |
| wb_op | input | 2 | Writeback-stage opcode |
| wb_dst | input | REG_ADDR_W | Writeback-stage destination index |
| mem_wait | input | 1 | Data memory read not yet complete |
| br_taken | input | 1 | Branch resolved as taken |
| br_target | input | PC_W | Branch destination address |
| fwd_a_sel | output | 2 | Operand A source select |
| fwd_b_sel | output | 2 | Operand B source select |
| load_use_stall | output | 1 | Effective load-use stall |
| stage_hold | output | 5 | Per-stage hold, bit 0 = fetch |
| stage_flush | output | 5 | Per-stage flush, bit 0 = fetch |
| ex_bubble | output | 1 | Insert NOP into execute |
| pc_sel | output | 2 | Program counter source |
| pc_q | output | PC_W | Program counter |

## Verification
The bench builds the main instance with REG_ADDR_W = 5, PC_W = 16 and PC_STEP = 4. The narrow PC lets a branch to 16'hFFFC show the counter wrapping to 0 within a few cycles. A second instance, built with FWD_ENABLE = 0, sees the same stimulus, so every bypass case also exercises the variant without bypassing. The table places a branch and a load-use hazard under an active memory wait, and a hazard beside a taken branch, so that every level of the priority order is reached.

// File: rtl/hz_pkg.sv
package hz_pkg;

   typedef enum logic [1:0] {
      OP_ADD   = 2'b00,
      OP_SUB   = 2'b01,
      OP_LOAD  = 2'b10,
      OP_STORE = 2'b11
   } hz_op_e;

   typedef enum logic [1:0] {
      SRC_RF  = 2'b00,
      SRC_MEM = 2'b01,
      SRC_WB  = 2'b10
   } hz_src_e;

   typedef enum logic [1:0] {
      PCS_STEP   = 2'b00,
      PCS_HOLD   = 2'b01,
      PCS_BRANCH = 2'b10
   } hz_pcsel_e;

   localparam int HZ_STAGES = 5;
   localparam int ST_IF  = 0;
   localparam int ST_ID  = 1;
   localparam int ST_EX  = 2;
   localparam int ST_MEM = 3;
   localparam int ST_WB  = 4;

   // opcode produces a result in the ALU (available at the memory stage)
   function automatic logic alu_result(input logic [1:0] op);
      return (op == OP_ADD) || (op == OP_SUB);
   endfunction

   // opcode writes the register file at writeback
   function automatic logic reg_result(input logic [1:0] op);
      return (op == OP_ADD) || (op == OP_SUB) || (op == OP_LOAD);
   endfunction

endpackage

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int REG_ADDR_W = 5
) (
   input  logic [1:0]            ex_op,
   input  logic [REG_ADDR_W-1:0] ex_dst,
   input  logic [REG_ADDR_W-1:0] id_src1,
   input  logic [REG_ADDR_W-1:0] id_src2,
   input  logic                  id_src2_imm,
   output logic                  hit
);
   import hz_pkg::*;

   logic is_load;
   logic match1;
   logic match2;

   always_comb begin
      is_load = (ex_op == OP_LOAD);
      match1  = (ex_dst == id_src1);
      match2  = !id_src2_imm && (ex_dst == id_src2);
      hit     = is_load && (match1 || match2);
   end

endmodule

// File: rtl/hz_fwd_pick.sv
module hz_fwd_pick #(
   parameter int REG_ADDR_W = 5,
   parameter bit FWD_ENABLE = 1'b1
) (
   input  logic [REG_ADDR_W-1:0] src,
   input  logic                  src_is_reg,
   input  logic [1:0]            mem_op,
   input  logic [REG_ADDR_W-1:0] mem_dst,
   input  logic [1:0]            wb_op,
   input  logic [REG_ADDR_W-1:0] wb_dst,
   output logic [1:0]            sel
);
   import hz_pkg::*;

   generate
      if (FWD_ENABLE) begin : g_bypass
         logic live;
         logic from_mem;
         logic from_wb;
         always_comb begin
            live     = src_is_reg && (src != '0);
            from_mem = live && alu_result(mem_op) && (mem_dst == src);
            from_wb  = live && reg_result(wb_op)  && (wb_dst  == src);
            if (from_mem)     sel = SRC_MEM;
            else if (from_wb) sel = SRC_WB;
            else              sel = SRC_RF;
         end
      end else begin : g_no_bypass
         assign sel = SRC_RF;
      end
   endgenerate

endmodule

// File: rtl/hz_stage_ctrl.sv
module hz_stage_ctrl #(
   parameter int PC_W     = 32,
   parameter int PC_STEP  = 4,
   parameter int N_STAGES = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                mem_wait,
   input  logic                br_taken,
   input  logic [PC_W-1:0]     br_target,
   input  logic                hazard,
   output logic                stall,
   output logic [N_STAGES-1:0] stage_hold,
   output logic [N_STAGES-1:0] stage_flush,
   output logic                ex_bubble,
   output logic [1:0]          pc_sel,
   output logic [PC_W-1:0]     pc_q
);
   import hz_pkg::*;

   localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

   // masks computed from stage positions
   function automatic logic [N_STAGES-1:0] upto(input int last);
      logic [N_STAGES-1:0] m;
      m = '0;
      for (int i = 0; i < N_STAGES; i++) m[i] = (i <= last);
      return m;
   endfunction

   localparam logic [N_STAGES-1:0] ALL_MASK   = '1;
   localparam logic [N_STAGES-1:0] STALL_MASK = upto(ST_ID);
   localparam logic [N_STAGES-1:0] FLUSH_MASK = upto(ST_EX);

   logic [PC_W-1:0] pc_d;

   always_comb begin
      stall       = 1'b0;
      stage_hold  = '0;
      stage_flush = '0;
      ex_bubble   = 1'b0;
      pc_sel      = PCS_STEP;
      pc_d        = pc_q + STEP_V;
      if (mem_wait) begin
         stage_hold = ALL_MASK;
         pc_sel     = PCS_HOLD;
         pc_d       = pc_q;
      end else if (br_taken) begin
         stage_flush = FLUSH_MASK;
         pc_sel      = PCS_BRANCH;
         pc_d        = br_target;
      end else if (hazard) begin
         stall      = 1'b1;
         stage_hold = STALL_MASK;
         ex_bubble  = 1'b1;
         pc_sel     = PCS_HOLD;
         pc_d       = pc_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= '0;
      else        pc_q <= pc_d;
   end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl #(
   parameter int REG_ADDR_W = 5,
   parameter int PC_W       = 32,
   parameter int PC_STEP    = 4,
   parameter int N_STAGES   = 5,
   parameter bit FWD_ENABLE = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] id_src1,
   input  logic [REG_ADDR_W-1:0] id_src2,
   input  logic                  id_src2_imm,
   input  logic [1:0]            ex_op,
   input  logic [REG_ADDR_W-1:0] ex_dst,
   input  logic [REG_ADDR_W-1:0] ex_src1,
   input  logic [REG_ADDR_W-1:0] ex_src2,
   input  logic                  ex_src2_imm,
   input  logic [1:0]            mem_op,
   input  logic [REG_ADDR_W-1:0] mem_dst,
   input  logic [1:0]            wb_op,
   input  logic [REG_ADDR_W-1:0] wb_dst,
   input  logic                  mem_wait,
   input  logic                  br_taken,
   input  logic [PC_W-1:0]       br_target,
   output logic [1:0]            fwd_a_sel,
   output logic [1:0]            fwd_b_sel,
   output logic                  load_use_stall,
   output logic [N_STAGES-1:0]   stage_hold,
   output logic [N_STAGES-1:0]   stage_flush,
   output logic                  ex_bubble,
   output logic [1:0]            pc_sel,
   output logic [PC_W-1:0]       pc_q
);
   localparam int N_OPERANDS = 2;

   generate
      if (N_STAGES != hz_pkg::HZ_STAGES) begin : g_bad_depth
         $error("pipe_hazard_ctrl: N_STAGES must be 5");
      end
      if (REG_ADDR_W < 1) begin : g_bad_addr
         $error("pipe_hazard_ctrl: REG_ADDR_W must be at least 1");
      end
      if (PC_W < 3 || PC_STEP < 1) begin : g_bad_pc
         $error("pipe_hazard_ctrl: PC_W or PC_STEP out of range");
      end
   endgenerate

   logic                  hazard;
   logic [REG_ADDR_W-1:0] opnd_src    [N_OPERANDS];
   logic                  opnd_is_reg [N_OPERANDS];
   logic [1:0]            opnd_sel    [N_OPERANDS];

   assign opnd_src[0]    = ex_src1;
   assign opnd_is_reg[0] = 1'b1;
   assign opnd_src[1]    = ex_src2;
   assign opnd_is_reg[1] = !ex_src2_imm;

   hz_load_use #(.REG_ADDR_W(REG_ADDR_W)) u_load_use (
      .ex_op       (ex_op),
      .ex_dst      (ex_dst),
      .id_src1     (id_src1),
      .id_src2     (id_src2),
      .id_src2_imm (id_src2_imm),
      .hit         (hazard)
   );

   generate
      for (genvar k = 0; k < N_OPERANDS; k++) begin : g_opnd
         hz_fwd_pick #(
            .REG_ADDR_W (REG_ADDR_W),
            .FWD_ENABLE (FWD_ENABLE)
         ) u_pick (
            .src        (opnd_src[k]),
            .src_is_reg (opnd_is_reg[k]),
            .mem_op     (mem_op),
            .mem_dst    (mem_dst),
            .wb_op      (wb_op),
            .wb_dst     (wb_dst),
            .sel        (opnd_sel[k])
         );
      end
   endgenerate

   assign fwd_a_sel = opnd_sel[0];
   assign fwd_b_sel = opnd_sel[1];

   hz_stage_ctrl #(
      .PC_W     (PC_W),
      .PC_STEP  (PC_STEP),
      .N_STAGES (N_STAGES)
   ) u_stage_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .mem_wait    (mem_wait),
      .br_taken    (br_taken),
      .br_target   (br_target),
      .hazard      (hazard),
      .stall       (load_use_stall),
      .stage_hold  (stage_hold),
      .stage_flush (stage_flush),
      .ex_bubble   (ex_bubble),
      .pc_sel      (pc_sel),
      .pc_q        (pc_q)
   );

endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
   parameter int REG_ADDR_W = 5,
   parameter int PC_W       = 32,
   parameter int PC_STEP    = 4,
   parameter int N_STAGES   = 5
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [REG_ADDR_W-1:0] ex_src1,
   input logic [REG_ADDR_W-1:0] ex_src2,
   input logic                  ex_src2_imm,
   input logic                  mem_wait,
   input logic                  br_taken,
   input logic [PC_W-1:0]       br_target,
   input logic [1:0]            fwd_a_sel,
   input logic [1:0]            fwd_b_sel,
   input logic                  load_use_stall,
   input logic [N_STAGES-1:0]   stage_hold,
   input logic [N_STAGES-1:0]   stage_flush,
   input logic                  ex_bubble,
   input logic [PC_W-1:0]       pc_q
);
   localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

   // R8
   wait_freezes_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wait |-> (stage_hold == '1 && stage_flush == '0 && !load_use_stall));

   // R8
   wait_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wait |=> $stable(pc_q));

   // R9
   branch_loads_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_taken && !mem_wait) |=> (pc_q == $past(br_target)));

   // R9
   flush_excludes_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_flush != '0) |-> (!load_use_stall && !ex_bubble));

   // R5
   stall_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_use_stall |=> $stable(pc_q));

   // R2
   pc_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_wait && !br_taken && !load_use_stall) |=> (pc_q == $past(pc_q) + STEP_V));

   // R7
   zero_src_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_src1 == '0) |-> (fwd_a_sel == 2'b00));

   // R7
   imm_src_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_src2_imm || ex_src2 == '0) |-> (fwd_b_sel == 2'b00));

endmodule

bind pipe_hazard_ctrl hz_ctrl_chk #(
   .REG_ADDR_W (REG_ADDR_W),
   .PC_W       (PC_W),
   .PC_STEP    (PC_STEP),
   .N_STAGES   (N_STAGES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ex_src1        (ex_src1),
   .ex_src2        (ex_src2),
   .ex_src2_imm    (ex_src2_imm),
   .mem_wait       (mem_wait),
   .br_taken       (br_taken),
   .br_target      (br_target),
   .fwd_a_sel      (fwd_a_sel),
   .fwd_b_sel      (fwd_b_sel),
   .load_use_stall (load_use_stall),
   .stage_hold     (stage_hold),
   .stage_flush    (stage_flush),
   .ex_bubble      (ex_bubble),
   .pc_q           (pc_q)
);

// File: tb/pipe_hazard_ctrl_tb.sv
module pipe_hazard_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int PW = 16;
   localparam int NV = 25;

   typedef struct packed {
      int id_s1; int id_s2; int id_imm;
      int ex_op; int ex_dst; int ex_s1; int ex_s2; int ex_imm;
      int mem_op; int mem_dst; int wb_op; int wb_dst;
      int wt; int br; int tgt;
      int fa; int fb; int st; int hold; int flush; int bub; int psel; int pc;
   } vec_t;

   // ops: 0 ADD, 1 SUB, 2 LOAD, 3 STORE
   localparam vec_t VECS [NV] = '{
      //  ids1 s2 imm exop dst s1 s2 imm mop mdst wop wdst wt br tgt    | fa fb st hold flush bub psel pc
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,0},         // 0  R2 NOP
      '{0,0,0, 0,3,1,1,0, 0,1, 0,0, 0,0,0,       1,1,0,0,0,0,0,4},         // 1  R6 ADD->ADD
      '{0,0,0, 0,3,2,5,0, 1,2, 0,5, 0,0,0,       1,2,0,0,0,0,0,8},         // 2  R6 MEM/WB
      '{0,0,0, 0,3,4,4,0, 0,4, 0,4, 0,0,0,       1,1,0,0,0,0,0,12},        // 3  R6 MEM wins
      '{0,0,0, 0,3,6,7,0, 2,6, 1,7, 0,0,0,       0,2,0,0,0,0,0,16},        // 4  R6 LOAD in MEM
      '{0,0,0, 0,3,9,9,1, 0,0, 2,9, 0,0,0,       2,0,0,0,0,0,0,20},        // 5  R7 imm B
      '{0,0,0, 0,3,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,24},        // 6  R7 reg0
      '{8,3,0, 2,8,0,0,0, 0,0, 0,0, 0,0,0,       0,0,1,3,0,1,1,28},        // 7  R3 R5 stall
      '{8,3,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,28},        // 8  R5 one bubble
      '{0,0,0, 0,4,8,0,0, 0,0, 2,8, 0,0,0,       2,0,0,0,0,0,0,32},        // 9  R6 load result
      '{1,5,0, 2,5,0,0,0, 0,0, 0,0, 0,0,0,       0,0,1,3,0,1,1,36},        // 10 R3 via src2
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,36},        // 11 R5
      '{1,5,1, 2,5,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,40},        // 12 R4 imm
      '{0,3,0, 2,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,1,3,0,1,1,44},        // 13 R3 reg0
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,44},        // 14
      '{8,0,0, 2,8,0,0,0, 0,0, 0,0, 1,1,256,     0,0,0,31,0,0,1,48},       // 15 R8 over all
      '{8,0,0, 2,8,0,0,0, 0,0, 0,0, 1,1,256,     0,0,0,31,0,0,1,48},       // 16 R8
      '{8,0,0, 2,8,0,0,0, 0,0, 0,0, 0,1,256,     0,0,0,0,7,0,2,48},        // 17 R9 over stall
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,256},       // 18 R9
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,260},       // 19
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 1,0,0,       0,0,0,31,0,0,1,264},      // 20 R8
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,264},       // 21
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,1,65532,   0,0,0,0,7,0,2,268},       // 22 R9
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,65532},     // 23
      '{0,0,0, 0,0,0,0,0, 0,0, 0,0, 0,0,0,       0,0,0,0,0,0,0,0}          // 24 R2 wrap
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] id_src1 = '0, id_src2 = '0, ex_dst = '0, ex_src1 = '0, ex_src2 = '0;
   logic [AW-1:0] mem_dst = '0, wb_dst = '0;
   logic id_src2_imm = 1'b0, ex_src2_imm = 1'b0, mem_wait = 1'b0, br_taken = 1'b0;
   logic [1:0] ex_op = '0, mem_op = '0, wb_op = '0;
   logic [PW-1:0] br_target = '0;

   logic [1:0] fwd_a_sel, fwd_b_sel, pc_sel;
   logic load_use_stall, ex_bubble;
   logic [4:0] stage_hold, stage_flush;
   logic [PW-1:0] pc_q;

   logic [1:0] n_fa, n_fb, n_psel;
   logic n_st, n_bub;
   logic [4:0] n_hold, n_flush;
   logic [PW-1:0] n_pc;

   int n_checks = 0;
   int n_fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pipe_hazard_ctrl #(.REG_ADDR_W(AW), .PC_W(PW), .PC_STEP(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .id_src1(id_src1), .id_src2(id_src2),
      .id_src2_imm(id_src2_imm), .ex_op(ex_op), .ex_dst(ex_dst), .ex_src1(ex_src1),
      .ex_src2(ex_src2), .ex_src2_imm(ex_src2_imm), .mem_op(mem_op), .mem_dst(mem_dst),
      .wb_op(wb_op), .wb_dst(wb_dst), .mem_wait(mem_wait), .br_taken(br_taken),
      .br_target(br_target), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
      .load_use_stall(load_use_stall), .stage_hold(stage_hold), .stage_flush(stage_flush),
      .ex_bubble(ex_bubble), .pc_sel(pc_sel), .pc_q(pc_q)
   );

   pipe_hazard_ctrl #(.REG_ADDR_W(AW), .PC_W(PW), .PC_STEP(4), .FWD_ENABLE(1'b0)) u_dut_nofwd (
      .clk(clk), .rst_n(rst_n), .id_src1(id_src1), .id_src2(id_src2),
      .id_src2_imm(id_src2_imm), .ex_op(ex_op), .ex_dst(ex_dst), .ex_src1(ex_src1),
      .ex_src2(ex_src2), .ex_src2_imm(ex_src2_imm), .mem_op(mem_op), .mem_dst(mem_dst),
      .wb_op(wb_op), .wb_dst(wb_dst), .mem_wait(mem_wait), .br_taken(br_taken),
      .br_target(br_target), .fwd_a_sel(n_fa), .fwd_b_sel(n_fb),
      .load_use_stall(n_st), .stage_hold(n_hold), .stage_flush(n_flush),
      .ex_bubble(n_bub), .pc_sel(n_psel), .pc_q(n_pc)
   );

   task automatic chk(input string req, input int idx, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s vec %0d: actual %0d expected %0d", req, idx, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk("R1 pc in reset", -1, int'(pc_q), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         id_src1     = AW'(VECS[i].id_s1);
         id_src2     = AW'(VECS[i].id_s2);
         id_src2_imm = VECS[i].id_imm[0];
         ex_op       = VECS[i].ex_op[1:0];
         ex_dst      = AW'(VECS[i].ex_dst);
         ex_src1     = AW'(VECS[i].ex_s1);
         ex_src2     = AW'(VECS[i].ex_s2);
         ex_src2_imm = VECS[i].ex_imm[0];
         mem_op      = VECS[i].mem_op[1:0];
         mem_dst     = AW'(VECS[i].mem_dst);
         wb_op       = VECS[i].wb_op[1:0];
         wb_dst      = AW'(VECS[i].wb_dst);
         mem_wait    = VECS[i].wt[0];
         br_taken    = VECS[i].br[0];
         br_target   = PW'(VECS[i].tgt);
         #1;
         chk("R6 R7 fwd_a_sel", i, int'(fwd_a_sel), VECS[i].fa);
         chk("R6 R7 fwd_b_sel", i, int'(fwd_b_sel), VECS[i].fb);
         chk("R3 R4 load_use_stall", i, int'(load_use_stall), VECS[i].st);
         chk("R5 R8 stage_hold", i, int'(stage_hold), VECS[i].hold);
         chk("R9 stage_flush", i, int'(stage_flush), VECS[i].flush);
         chk("R5 ex_bubble", i, int'(ex_bubble), VECS[i].bub);
         chk("R2 pc_sel", i, int'(pc_sel), VECS[i].psel);
         chk("R2 R9 pc_q", i, int'(pc_q), VECS[i].pc);
         chk("R10 no-bypass a", i, int'(n_fa), 0);
         chk("R10 no-bypass b", i, int'(n_fb), 0);
         @(negedge clk);
      end
      // R1: asynchronous reset mid-run clears the PC at once and keeps it there
      rst_n = 1'b0;
      #1;
      chk("R1 pc on async reset", 100, int'(pc_q), 0);
      @(negedge clk);
      #1;
      chk("R1 pc held in reset", 101, int'(pc_q), 0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule